// File: doc/BRIEF.md
# Codec power-mode and status controller

This controller supervises the operating modes of a compression/decompression engine. It qualifies the engine's active-low reset pin, tracks clock stability after the clock enable rises, and enforces when standby may be entered and when internal memory may be touched. It also holds the engine in place while freeze is asserted and keeps the end-of-process flag and the status and interrupt bits. It never starts or stops the datapath itself. It only reports the mode and raises a one-cycle violation pulse when the surrounding system breaks one of the power or sequencing rules.

A separate asynchronous power-on reset (`arst_n`) brings the flops to a defined state. The device reset pin (`reset_req_n`) is a protocol input, and it is honoured only when it is asserted long enough with the clock enabled. PLL lock is modelled as a counter of clock-enabled cycles.

Top module: `codec_mode_ctrl`

## Requirements
- R1: A device reset takes effect at the RST_MIN-th consecutive rising edge that samples `reset_req_n` low with `clk_en` high. If `reset_req_n` returns high after 1 to RST_MIN-1 such edges, nothing changes and `violation` pulses high for one cycle. If `clk_en` is low, `reset_req_n` has no effect.
- R2: A device reset selects mode 0 (idle) and drives `end_n` low, `comp_mode` high and `stop` high. It clears `status0`, `irq` and `status1[1]`, and sets `status1[0]`. Mode codes are: 0 idle, 1 active, 2 standby, 3 standby with clock off, 4 frozen.
- R3: `clk_ready` rises after LOCK_CYCLES consecutive edges that sample `clk_en` high. Any edge that samples `clk_en` low clears it and restarts the count.
- R4: `stby_n` low moves the controller from idle to standby. The mode is 2, or 3 while `clk_en` is low. In active, `stby_n` low is refused, the mode stays 1 and `violation` pulses.
- R5: `mem_ok` is high only when all of these hold: clock ready, not in standby, not frozen, and SBY_GAP or more edges have sampled `stby_n` high since it was last low. A `mem_req` sampled while `stby_n` is low, while in standby, or before that gap has elapsed makes `violation` pulse.
- R6: `freeze_n` low sampled at an edge drives `bus_float` high and the mode to 4 from the next cycle. While frozen, `go`, `done`, `ovf` and `stat1_rd` are ignored and all state holds. After release, operation resumes in the same mode.
- R7: `go` is accepted only in idle with `clk_ready` high and not frozen. Acceptance gives mode 1, `end_n` high, `stop` low and `status0` high. In any other case `go` has no effect.
- R8: In active, `done` returns the controller to idle, drives `end_n` low, sets `irq[0]`, sets `status1[0]` and raises `stop`.
- R9: In active, `ovf` returns the controller to idle with `end_n` high, sets `status1[1]` and `irq[1]`, and raises `stop`. If `ovf` and `done` arrive together, `ovf` wins.
- R10: `stat1_rd` clears the end flag (`end_n` goes high). If `done` and `stat1_rd` fall in the same active cycle, `done` wins and `end_n` goes low.
- R11: An edge that samples `clk_en` low while `stby_n` is high makes `violation` pulse.
- R12: `status1[2]` is high in the cycle after each edge that samples `reset_req_n` low, `stby_n` low and `clk_en` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous power-on reset, active low |
| reset_req_n | input | 1 | Device reset pin, active low, qualified |
| stby_n | input | 1 | Standby request, active low |
| clk_en | input | 1 | Clock enable, active high |
| freeze_n | input | 1 | Freeze request, active low |
| go | input | 1 | Start command |
| stat1_rd | input | 1 | Status-1 read strobe |
| done | input | 1 | Normal end of process |
| ovf | input | 1 | Encoding ended by overflow |
| mem_req | input | 1 | Internal-memory access attempt |
| clk_ready | output | 1 | Clock stable after lock wait |
| end_n | output | 1 | End-of-process flag, active low |
| bus_float | output | 1 | Buses to be floated |
| mem_ok | output | 1 | Memory access allowed |
| violation | output | 1 | One-cycle protocol violation pulse |
| comp_mode | output | 1 | Compression mode selected |
| stop | output | 1 | Engine stopped |
| mode | output | 3 | Mode code per R2 |
| status0 | output | 1 | Run-started status bit |
| status1 | output | 3 | {normal current, overflow, end} |
| irq | output | 2 | {overflow, done} interrupt requests |

## Verification
`done` and `stat1_rd` can fall in the same active cycle, and `ovf` can coincide with either of them. The bench drives all eight combinations of the three strobes for one cycle, each from a freshly reset active state. It judges the result from the priority rules (overflow over done, done over the read) by checking mode, `end_n`, `stop`, the overflow status bit and both interrupt bits.

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl #(
  parameter int LOCK_CYCLES = 5000,
  parameter int RST_MIN     = 4,
  parameter int SBY_GAP     = 4
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       reset_req_n,
  input  logic       stby_n,
  input  logic       clk_en,
  input  logic       freeze_n,
  input  logic       go,
  input  logic       stat1_rd,
  input  logic       done,
  input  logic       ovf,
  input  logic       mem_req,
  output logic       clk_ready,
  output logic       end_n,
  output logic       bus_float,
  output logic       mem_ok,
  output logic       violation,
  output logic       comp_mode,
  output logic       stop,
  output logic [2:0] mode,
  output logic       status0,
  output logic [2:0] status1,
  output logic [1:0] irq
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam int RW = $clog2(RST_MIN + 1);
  localparam int GW = $clog2(SBY_GAP + 1);
  localparam logic [LW-1:0] LOCK_END = LW'(LOCK_CYCLES);
  localparam logic [RW-1:0] RST_END  = RW'(RST_MIN);
  localparam logic [GW-1:0] GAP_END  = GW'(SBY_GAP);

  typedef enum logic [1:0] {S_IDLE, S_ACT, S_SBY} st_t;

  st_t         st;
  logic [LW-1:0] lcnt;
  logic [RW-1:0] rcnt, rcnt_nx;
  logic [GW-1:0] gcnt;
  logic        frz, end_f, ovf_f, nc_f, run_f, viol_q, comp_q, stop_q;
  logic [1:0]  irq_q;
  logic        dev_rst, short_rst, go_ok, mem_bad, sby_bad, en_bad;

  assign clk_ready = (lcnt == LOCK_END);

  assign rcnt_nx   = (!reset_req_n && clk_en) ? ((rcnt == RST_END) ? rcnt : rcnt + 1'b1) : '0;
  assign dev_rst   = (rcnt_nx == RST_END);
  assign short_rst = reset_req_n && (rcnt != '0) && (rcnt < RST_END);
  assign go_ok     = go && (st == S_IDLE) && clk_ready;
  assign mem_bad   = mem_req && (!stby_n || st == S_SBY || gcnt < GAP_END);
  assign sby_bad   = !stby_n && (st == S_ACT);
  assign en_bad    = stby_n && !clk_en;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n)          lcnt <= '0;
    else if (!clk_en)     lcnt <= '0;
    else if (!clk_ready)  lcnt <= lcnt + 1'b1;

  always_ff @(posedge clk or negedge arst_n)
    if (!arst_n) frz <= 1'b0;
    else         frz <= !freeze_n;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st <= S_IDLE;  rcnt <= '0;  gcnt <= GAP_END;
      end_f <= 1'b1; ovf_f <= 1'b0; nc_f <= 1'b0; run_f <= 1'b0;
      viol_q <= 1'b0; comp_q <= 1'b1; stop_q <= 1'b1; irq_q <= '0;
    end else if (frz) begin
      viol_q <= 1'b0;
    end else begin
      rcnt   <= rcnt_nx;
      nc_f   <= !reset_req_n && !stby_n && clk_en;
      viol_q <= short_rst | mem_bad | sby_bad | en_bad;
      if (!stby_n)               gcnt <= '0;
      else if (gcnt != GAP_END)  gcnt <= gcnt + 1'b1;
      if (dev_rst) begin
        st <= S_IDLE; end_f <= 1'b1; ovf_f <= 1'b0; run_f <= 1'b0;
        comp_q <= 1'b1; stop_q <= 1'b1; irq_q <= '0;
      end else begin
        if (stat1_rd) end_f <= 1'b0;
        case (st)
          S_IDLE:
            if (go_ok) begin
              st <= S_ACT; end_f <= 1'b0; stop_q <= 1'b0; run_f <= 1'b1;
            end else if (!stby_n) st <= S_SBY;
          S_ACT:
            if (ovf) begin
              st <= S_IDLE; end_f <= 1'b0; ovf_f <= 1'b1; irq_q[1] <= 1'b1; stop_q <= 1'b1;
            end else if (done) begin
              st <= S_IDLE; end_f <= 1'b1; irq_q[0] <= 1'b1; stop_q <= 1'b1;
            end
          S_SBY:
            if (stby_n) st <= S_IDLE;
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assign end_n     = ~end_f;
  assign bus_float = frz;
  assign mem_ok    = clk_ready && !frz && (st != S_SBY) && (gcnt == GAP_END);
  assign violation = viol_q;
  assign comp_mode = comp_q;
  assign stop      = stop_q;
  assign status0   = run_f;
  assign status1   = {nc_f, ovf_f, end_f};
  assign irq       = irq_q;
  assign mode      = frz ? 3'd4 :
                     (st == S_SBY) ? (clk_en ? 3'd2 : 3'd3) :
                     (st == S_ACT) ? 3'd1 : 3'd0;

  p_reset_effect_r2: assert property (@(posedge clk) disable iff (!arst_n)
    (dev_rst && !frz) |=> (!end_n && stop && comp_mode && irq == 2'b00 && !status0));
  p_ready_drop_r3: assert property (@(posedge clk) disable iff (!arst_n)
    !clk_en |=> !clk_ready);
  p_stby_refused_r4: assert property (@(posedge clk) disable iff (!arst_n)
    (sby_bad && !frz && !dev_rst) |=> (violation && st == S_ACT));
  p_mem_blocked_r5: assert property (@(posedge clk) disable iff (!arst_n)
    !stby_n |=> !mem_ok);
  p_float_r6: assert property (@(posedge clk) disable iff (!arst_n)
    !freeze_n |=> bus_float);
  p_hold_r6: assert property (@(posedge clk) disable iff (!arst_n)
    frz |=> ($stable(st) && $stable(end_f) && $stable(irq_q) && $stable(ovf_f)));
  p_go_accept_r7: assert property (@(posedge clk) disable iff (!arst_n)
    (go && st == S_IDLE && clk_ready && !frz && !dev_rst) |=> (st == S_ACT && end_n && !stop));
  p_done_end_r8: assert property (@(posedge clk) disable iff (!arst_n)
    (st == S_ACT && done && !ovf && !frz && !dev_rst) |=> (!end_n && st == S_IDLE));
  p_ovf_no_end_r9: assert property (@(posedge clk) disable iff (!arst_n)
    (st == S_ACT && ovf && !frz && !dev_rst) |=> (end_n && st == S_IDLE && status1[1]));
endmodule

// File: tb/codec_mode_ctrl_bench.sv
`timescale 1ns/1ps
module codec_mode_ctrl_bench;
  localparam int LOCK = 12;
  localparam int RMIN = 4;
  localparam int GAP  = 4;

  logic clk = 1'b0;
  logic arst_n = 1'b0, reset_req_n = 1'b1, stby_n = 1'b1, clk_en = 1'b1, freeze_n = 1'b1;
  logic go = 1'b0, stat1_rd = 1'b0, done = 1'b0, ovf = 1'b0, mem_req = 1'b0;
  logic clk_ready, end_n, bus_float, mem_ok, violation, comp_mode, stop, status0;
  logic [2:0] mode, status1;
  logic [1:0] irq;
  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  codec_mode_ctrl #(.LOCK_CYCLES(LOCK), .RST_MIN(RMIN), .SBY_GAP(GAP)) u_codec_mode_ctrl (
    .clk(clk), .arst_n(arst_n), .reset_req_n(reset_req_n), .stby_n(stby_n), .clk_en(clk_en),
    .freeze_n(freeze_n), .go(go), .stat1_rd(stat1_rd), .done(done), .ovf(ovf), .mem_req(mem_req),
    .clk_ready(clk_ready), .end_n(end_n), .bus_float(bus_float), .mem_ok(mem_ok),
    .violation(violation), .comp_mode(comp_mode), .stop(stop), .mode(mode), .status0(status0),
    .status1(status1), .irq(irq));

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #2;
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  task automatic dev_reset();
    reset_req_n = 1'b0; step(RMIN);
    reset_req_n = 1'b1; step(1);
  endtask

  task automatic start_run();
    go = 1'b1; step(1); go = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    step(2);
    arst_n = 1'b1;
    step(1);
    // R2 power-on state
    chk("R2 mode", mode, 0); chk("R2 end_n", end_n, 0); chk("R2 comp", comp_mode, 1);
    chk("R2 stop", stop, 1); chk("R3 not ready", clk_ready, 0);
    step(LOCK);
    chk("R3 ready after wait", clk_ready, 1);

    // R3 lock sweep with restart
    stby_n = 1'b0; step(1);
    chk("R4 standby from idle", mode, 2);
    clk_en = 1'b0; step(1);
    chk("R3 dropped", clk_ready, 0); chk("R4 clock-off standby", mode, 3);
    chk("R11 no viol in standby", violation, 0);
    clk_en = 1'b1;
    for (int i = 1; i <= LOCK + 2; i++) begin
      step(1);
      chk("R3 lock sweep", clk_ready, (i >= LOCK) ? 1 : 0);
    end
    step(LOCK - 3); clk_en = 1'b0; step(1); clk_en = 1'b1;
    step(LOCK - 1); chk("R3 restart not ready", clk_ready, 0);
    step(1);        chk("R3 restart ready", clk_ready, 1);

    // R1 ignored while clock disabled; R12 normal-current bit
    stat1_rd = 1'b1; step(1); stat1_rd = 1'b0;
    chk("R10 read clears end", end_n, 1);
    reset_req_n = 1'b0; step(1);
    chk("R12 normal current", status1[2], 1);
    reset_req_n = 1'b1; step(1);
    chk("R12 normal current off", status1[2], 0);
    clk_en = 1'b0; reset_req_n = 1'b0; step(6);
    chk("R12 clock off no bit", status1[2], 0);
    reset_req_n = 1'b1; step(1);
    chk("R1 clock-off reset ignored end", end_n, 1);
    chk("R1 clock-off reset ignored mode", mode, 3);
    clk_en = 1'b1; step(1); stby_n = 1'b1; step(LOCK + GAP);

    // R1 pulse-length sweep
    for (int len = 1; len <= 6; len++) begin
      dev_reset(); start_run();
      chk("R7 active", mode, 1);
      reset_req_n = 1'b0; step(len); reset_req_n = 1'b1; step(1);
      chk("R1 short flag", violation, (len < RMIN) ? 1 : 0);
      chk("R1 mode", mode, (len < RMIN) ? 1 : 0);
      chk("R2 end_n", end_n, (len < RMIN) ? 1 : 0);
      chk("R2 status0", status0, (len < RMIN) ? 1 : 0);
    end

    // R8 R9 R10 strobe-combination sweep
    for (int c = 0; c < 8; c++) begin
      logic d, o, r;
      d = c[0]; o = c[1]; r = c[2];
      dev_reset(); start_run();
      chk("R7 end cleared by go", end_n, 1); chk("R7 stop low", stop, 0);
      done = d; ovf = o; stat1_rd = r; step(1);
      done = 1'b0; ovf = 1'b0; stat1_rd = 1'b0;
      chk("R8 R9 mode", mode, (d | o) ? 0 : 1);
      chk("R9 R10 end_n", end_n, (d & !o) ? 0 : 1);
      chk("R9 ovf bit", status1[1], o);
      chk("R8 R9 irq", irq, {o, d & !o});
      chk("R8 R9 stop", stop, d | o);
    end

    // R7 refusals
    dev_reset();
    stby_n = 1'b0; step(1); start_run();
    chk("R7 go refused in standby", mode, 2);
    stby_n = 1'b1; step(GAP);
    freeze_n = 1'b0; step(1); start_run();
    chk("R6 frozen mode", mode, 4);
    freeze_n = 1'b1; step(1);
    chk("R7 go refused frozen", mode, 0);
    stby_n = 1'b0; clk_en = 1'b0; step(1); clk_en = 1'b1; step(1); stby_n = 1'b1; step(1);
    start_run();
    chk("R7 go refused not ready", mode, 0);
    step(LOCK);

    // R6 freeze holds active state
    start_run();
    freeze_n = 1'b0; step(1);
    chk("R6 float", bus_float, 1); chk("R6 mode", mode, 4);
    done = 1'b1; stat1_rd = 1'b1; step(1); done = 1'b0; stat1_rd = 1'b0;
    chk("R6 end held", end_n, 1);
    freeze_n = 1'b1; step(1);
    chk("R6 resume", mode, 1); chk("R6 unfloat", bus_float, 0); chk("R6 irq held", irq, 0);

    // R4 standby refused while active
    stby_n = 1'b0; step(1);
    chk("R4 refused viol", violation, 1); chk("R4 still active", mode, 1);
    chk("R5 no mem during standby req", mem_ok, 0);
    stby_n = 1'b1; done = 1'b1; step(1); done = 1'b0;

    // R5 memory gap sweep
    stby_n = 1'b0; step(1);
    mem_req = 1'b1; step(1); mem_req = 1'b0;
    chk("R5 access in standby", violation, 1);
    stby_n = 1'b1;
    for (int k = 1; k <= GAP + 2; k++) begin
      step(1);
      chk("R5 gap sweep", mem_ok, (k >= GAP) ? 1 : 0);
    end
    stby_n = 1'b0; step(1); stby_n = 1'b1; step(1);
    mem_req = 1'b1; step(1); mem_req = 1'b0;
    chk("R5 early access", violation, 1);
    step(GAP);
    mem_req = 1'b1; step(1); mem_req = 1'b0;
    chk("R5 legal access", violation, 0);

    // R11 clock enable low while standby high
    clk_en = 1'b0; step(1); clk_en = 1'b1;
    chk("R11 viol", violation, 1);
    step(1);
    chk("R11 pulse ends", violation, 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule